// File: doc/BRIEF.md
# In-band XON/XOFF Flow Controller

This block gives a UART automatic software flow control. It sits between the receiver and the receive FIFO. It checks every received byte against programmed resume and suspend codes. When a suspend code arrives, it pauses the local transmitter. When a resume code arrives, it releases the transmitter. Bytes recognised as flow codes are removed from the data stream. Every other byte passes to the FIFO. The codes can be single characters, or pairs of characters that must arrive back to back.

On the transmit side, the block watches the fill level of the local receive FIFO. When the level reaches a high threshold, it asks the transmitter to insert a suspend code (or code pair). When the level has drained to a low threshold, it asks for a resume code. Each requested character is handed over through a request/acknowledge pair. The transmitter raises the acknowledge only between characters, so an inserted code goes ahead of the next FIFO byte without cutting into a frame that is already shifting out.

The four code values, the mode bit and the two thresholds come from the host's configuration registers, which reset to zero. Received-byte strobes are at least two clock cycles apart, which always holds for a serial receiver.

Top module: `inband_flow_ctl`

## Requirements
- R1: After reset, `tx_pause`, `ins_req` and `dat_vld` are all 0.
- R2: With `sw_fc_en`=1 and `pair_mode`=0, a received byte equal to `stop_c0` sets `tx_pause` to 1 in the cycle after its strobe, and the byte is not delivered on `dat_vld`.
- R3: With `sw_fc_en`=1 and `pair_mode`=0, a received byte equal to `go_c0` clears `tx_pause` in the cycle after its strobe, and the byte is not delivered.
- R4: With `pair_mode`=1, `stop_c0` followed by `stop_c1` sets `tx_pause`, and `go_c0` followed by `go_c1` clears it. Neither byte of a matched pair is delivered, and `stop_c1` or `go_c1` on its own is ordinary data.
- R5: With `pair_mode`=1, a first-code match followed by a byte that does not complete the pair delivers both bytes in arrival order. The held byte appears in the cycle after the second strobe, and the second byte appears one cycle later. `tx_pause` is left unchanged.
- R6: Every byte that is not a flow code is presented on `dat_vld`/`dat_byte` in the cycle after its strobe. With `sw_fc_en`=0, every byte, including code values, is delivered.
- R7: Driving `sw_fc_en` low clears `tx_pause` and withdraws `ins_req` in the following cycle.
- R8: While the far end is not stopped, a level at or above `lvl_hi` raises `ins_req` in the next cycle, with `ins_byte`=`stop_c0`. In pair mode, `stop_c1` follows. `ins_byte` holds steady until `ins_ack`, and each acknowledge consumes exactly one character.
- R9: Once the suspend sequence is sent, no further request is made until the level falls to or below `lvl_lo`. The block then requests `go_c0` (then `go_c1` in pair mode).
- R10: A byte that matches both a suspend code and a resume code is treated as suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_fc_en | input | 1 | Enables software flow control |
| pair_mode | input | 1 | 1 = two-character codes, 0 = single character |
| go_c0 | input | 8 | Resume code, first character |
| go_c1 | input | 8 | Resume code, second character |
| stop_c0 | input | 8 | Suspend code, first character |
| stop_c1 | input | 8 | Suspend code, second character |
| lvl_hi | input | 8 | FIFO level that triggers a suspend request |
| lvl_lo | input | 8 | FIFO level that triggers a resume request |
| fifo_lvl | input | 8 | Current receive FIFO fill level |
| rx_stb | input | 1 | One-cycle strobe: a received byte is ready |
| rx_byte | input | 8 | Received byte |
| dat_vld | output | 1 | Data byte for the receive FIFO is valid |
| dat_byte | output | 8 | Data byte for the receive FIFO |
| tx_pause | output | 1 | Holds the local transmitter |
| ins_req | output | 1 | Request to insert a flow character |
| ins_byte | output | 8 | Character to insert |
| ins_ack | input | 1 | Transmitter has taken the inserted character |

## Verification
The bench builds the block with its default 8-bit code and level widths. Every level from empty to full can be driven, so the thresholds can be tested at their exact edges. The codes are chosen to be distinct and non-zero, so that a code byte reaching the data path stands out clearly. Separate directed runs set one suspend code equal to a resume code, which exercises the suspend-first rule. They also switch the pair mode on to reach the held-byte and split-pair paths.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  localparam int CODE_W = 8;

  typedef struct packed {
    logic [CODE_W-1:0] go0;
    logic [CODE_W-1:0] go1;
    logic [CODE_W-1:0] stop0;
    logic [CODE_W-1:0] stop1;
  } code_set_t;

  typedef enum logic [1:0] {
    TQ_IDLE   = 2'd0,
    TQ_FIRST  = 2'd1,
    TQ_SECOND = 2'd2
  } tq_state_e;
endpackage

// File: rtl/flowctl_rx_match.sv
module flowctl_rx_match
  import flowctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_fc_en,
  input  logic              pair_mode,
  input  code_set_t         codes,
  input  logic              rx_stb,
  input  logic [CODE_W-1:0] rx_byte,
  output logic              dat_vld,
  output logic [CODE_W-1:0] dat_byte,
  output logic              tx_pause
);
  function automatic logic code_hit(input logic [CODE_W-1:0] b,
                                    input logic [CODE_W-1:0] c);
    return b == c;
  endfunction

  logic              held_v, held_go, held_stop;
  logic [CODE_W-1:0] held_byte;
  logic              pend_v;
  logic [CODE_W-1:0] pend_byte;

  logic              n_dat_vld, n_pause, n_held_v, n_held_go, n_held_stop, n_pend_v;
  logic [CODE_W-1:0] n_dat_byte, n_held_byte, n_pend_byte;

  // named events for the assertions
  logic ev_stop, ev_go, ev_split;

  always_comb begin
    n_dat_vld   = 1'b0;
    n_dat_byte  = dat_byte;
    n_pend_v    = 1'b0;
    n_pend_byte = pend_byte;
    n_held_v    = held_v;
    n_held_go   = held_go;
    n_held_stop = held_stop;
    n_held_byte = held_byte;
    n_pause     = tx_pause;
    ev_stop     = 1'b0;
    ev_go       = 1'b0;
    ev_split    = 1'b0;
    if (pend_v) begin
      n_dat_vld  = 1'b1;
      n_dat_byte = pend_byte;
    end
    if (!sw_fc_en) begin
      n_pause  = 1'b0;
      n_held_v = 1'b0;
      if (held_v) begin
        n_dat_vld  = 1'b1;
        n_dat_byte = held_byte;
        if (rx_stb) begin
          n_pend_v    = 1'b1;
          n_pend_byte = rx_byte;
        end
      end else if (rx_stb) begin
        n_dat_vld  = 1'b1;
        n_dat_byte = rx_byte;
      end
    end else if (rx_stb) begin
      if (held_v) begin
        n_held_v = 1'b0;
        if (held_stop && code_hit(rx_byte, codes.stop1)) begin
          n_pause = 1'b1;
          ev_stop = 1'b1;
        end else if (held_go && code_hit(rx_byte, codes.go1)) begin
          n_pause = 1'b0;
          ev_go   = 1'b1;
        end else begin
          ev_split    = 1'b1;
          n_dat_vld   = 1'b1;
          n_dat_byte  = held_byte;
          n_pend_v    = 1'b1;
          n_pend_byte = rx_byte;
        end
      end else if (!pair_mode) begin
        if (code_hit(rx_byte, codes.stop0)) begin
          n_pause = 1'b1;
          ev_stop = 1'b1;
        end else if (code_hit(rx_byte, codes.go0)) begin
          n_pause = 1'b0;
          ev_go   = 1'b1;
        end else begin
          n_dat_vld  = 1'b1;
          n_dat_byte = rx_byte;
        end
      end else begin
        if (code_hit(rx_byte, codes.stop0) || code_hit(rx_byte, codes.go0)) begin
          n_held_v    = 1'b1;
          n_held_byte = rx_byte;
          n_held_stop = code_hit(rx_byte, codes.stop0);
          n_held_go   = code_hit(rx_byte, codes.go0);
        end else begin
          n_dat_vld  = 1'b1;
          n_dat_byte = rx_byte;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_vld   <= 1'b0;
      dat_byte  <= '0;
      tx_pause  <= 1'b0;
      held_v    <= 1'b0;
      held_go   <= 1'b0;
      held_stop <= 1'b0;
      held_byte <= '0;
      pend_v    <= 1'b0;
      pend_byte <= '0;
    end else begin
      dat_vld   <= n_dat_vld;
      dat_byte  <= n_dat_byte;
      tx_pause  <= n_pause;
      held_v    <= n_held_v;
      held_go   <= n_held_go;
      held_stop <= n_held_stop;
      held_byte <= n_held_byte;
      pend_v    <= n_pend_v;
      pend_byte <= n_pend_byte;
    end
  end

  // R2 / R4: a recognised suspend code leaves the transmitter paused
  p_stop_pauses_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> tx_pause);
  // R3 / R4: a recognised resume code releases it
  p_go_resumes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_go |=> !tx_pause);
  // R5: a broken pair delivers the held byte first
  p_split_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_split |=> dat_vld && dat_byte == $past(held_byte));
  // R5: then the byte that broke the pair
  p_split_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_split |=> ##1 dat_vld && dat_byte == $past(rx_byte, 2));
  // R7: disabling releases the transmitter
  p_disable_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_fc_en |=> !tx_pause);
  // R2: a recognised code never reaches the data path
  p_code_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop || ev_go) && !pend_v |=> !dat_vld);
endmodule

// File: rtl/flowctl_tx_req.sv
module flowctl_tx_req
  import flowctl_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_fc_en,
  input  logic              pair_mode,
  input  code_set_t         codes,
  input  logic [LVL_W-1:0]  fifo_lvl,
  input  logic [LVL_W-1:0]  lvl_hi,
  input  logic [LVL_W-1:0]  lvl_lo,
  input  logic              ins_ack,
  output logic              ins_req,
  output logic [CODE_W-1:0] ins_byte
);
  function automatic logic lvl_reached(input logic [LVL_W-1:0] lvl,
                                       input logic [LVL_W-1:0] thr);
    return lvl >= thr;
  endfunction

  function automatic logic lvl_drained(input logic [LVL_W-1:0] lvl,
                                       input logic [LVL_W-1:0] thr);
    return lvl <= thr;
  endfunction

  tq_state_e state;
  logic      want_stop;
  logic      far_stopped;
  logic      last_ack;

  assign last_ack = ins_ack && ((state == TQ_SECOND) || (state == TQ_FIRST && !pair_mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= TQ_IDLE;
      want_stop   <= 1'b0;
      far_stopped <= 1'b0;
    end else if (!sw_fc_en) begin
      state       <= TQ_IDLE;
      far_stopped <= 1'b0;
    end else begin
      unique case (state)
        TQ_IDLE: begin
          if (!far_stopped && lvl_reached(fifo_lvl, lvl_hi)) begin
            state     <= TQ_FIRST;
            want_stop <= 1'b1;
          end else if (far_stopped && lvl_drained(fifo_lvl, lvl_lo)) begin
            state     <= TQ_FIRST;
            want_stop <= 1'b0;
          end
        end
        TQ_FIRST: begin
          if (ins_ack) begin
            if (pair_mode) state <= TQ_SECOND;
            else begin
              state       <= TQ_IDLE;
              far_stopped <= want_stop;
            end
          end
        end
        TQ_SECOND: begin
          if (ins_ack) begin
            state       <= TQ_IDLE;
            far_stopped <= want_stop;
          end
        end
        default: state <= TQ_IDLE;
      endcase
    end
  end

  assign ins_req = (state != TQ_IDLE);

  always_comb begin
    if (want_stop) ins_byte = (state == TQ_SECOND) ? codes.stop1 : codes.stop0;
    else           ins_byte = (state == TQ_SECOND) ? codes.go1   : codes.go0;
  end

  // R8: an unacknowledged request stays up with a stable character
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req && !ins_ack && sw_fc_en |=> ins_req && $stable(ins_byte));
  // R9: completing a sequence records the far end's new state
  p_seq_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fc_en && last_ack |=> far_stopped == $past(want_stop) && !ins_req);
  // R7: no request while disabled
  p_no_req_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_fc_en |=> !ins_req);
endmodule

// File: rtl/inband_flow_ctl.sv
module inband_flow_ctl
  import flowctl_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_fc_en,
  input  logic              pair_mode,
  input  logic [CODE_W-1:0] go_c0,
  input  logic [CODE_W-1:0] go_c1,
  input  logic [CODE_W-1:0] stop_c0,
  input  logic [CODE_W-1:0] stop_c1,
  input  logic [LVL_W-1:0]  lvl_hi,
  input  logic [LVL_W-1:0]  lvl_lo,
  input  logic [LVL_W-1:0]  fifo_lvl,
  input  logic              rx_stb,
  input  logic [CODE_W-1:0] rx_byte,
  output logic              dat_vld,
  output logic [CODE_W-1:0] dat_byte,
  output logic              tx_pause,
  output logic              ins_req,
  output logic [CODE_W-1:0] ins_byte,
  input  logic              ins_ack
);
  code_set_t codes;
  assign codes = '{go0: go_c0, go1: go_c1, stop0: stop_c0, stop1: stop_c1};

  flowctl_rx_match u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_fc_en (sw_fc_en),
    .pair_mode(pair_mode),
    .codes    (codes),
    .rx_stb   (rx_stb),
    .rx_byte  (rx_byte),
    .dat_vld  (dat_vld),
    .dat_byte (dat_byte),
    .tx_pause (tx_pause)
  );

  flowctl_tx_req #(.LVL_W(LVL_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_fc_en (sw_fc_en),
    .pair_mode(pair_mode),
    .codes    (codes),
    .fifo_lvl (fifo_lvl),
    .lvl_hi   (lvl_hi),
    .lvl_lo   (lvl_lo),
    .ins_ack  (ins_ack),
    .ins_req  (ins_req),
    .ins_byte (ins_byte)
  );

  // R1: nothing is asserted straight out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !tx_pause && !ins_req && !dat_vld);
endmodule

// File: tb/sim_inband_flow_ctl.sv
module sim_inband_flow_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_fc_en = 1'b0, pair_mode = 1'b0;
  logic [7:0] go_c0 = 8'h11, go_c1 = 8'h91, stop_c0 = 8'h13, stop_c1 = 8'h93;
  logic [7:0] lvl_hi = 8'd100, lvl_lo = 8'd20, fifo_lvl = 8'd0;
  logic       rx_stb = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ins_ack = 1'b0;
  wire        dat_vld, tx_pause, ins_req;
  wire  [7:0] dat_byte, ins_byte;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  inband_flow_ctl u0 (
    .clk(clk), .rst_n(rst_n), .sw_fc_en(sw_fc_en), .pair_mode(pair_mode),
    .go_c0(go_c0), .go_c1(go_c1), .stop_c0(stop_c0), .stop_c1(stop_c1),
    .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .fifo_lvl(fifo_lvl),
    .rx_stb(rx_stb), .rx_byte(rx_byte),
    .dat_vld(dat_vld), .dat_byte(dat_byte), .tx_pause(tx_pause),
    .ins_req(ins_req), .ins_byte(ins_byte), .ins_ack(ins_ack)
  );

  // {byte, expected dat_vld, expected tx_pause}, single-character mode
  localparam logic [9:0] VEC [8] = '{
    {8'h41, 1'b1, 1'b0}, {8'h13, 1'b0, 1'b1}, {8'h42, 1'b1, 1'b1},
    {8'h13, 1'b0, 1'b1}, {8'h11, 1'b0, 1'b0}, {8'h91, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b0}, {8'h11, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobe one byte; returns at the negedge where its result is visible
  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_stb = 1'b1; rx_byte = b;
    @(negedge clk); rx_stb = 1'b0;
  endtask

  task automatic gap;
    @(negedge clk);
  endtask

  task automatic ack_one;
    ins_ack = 1'b1;
    @(negedge clk); ins_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pause", {15'd0, tx_pause}, 16'd0);
    chk("R1 req",   {15'd0, ins_req},  16'd0);
    chk("R1 vld",   {15'd0, dat_vld},  16'd0);

    sw_fc_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      send(VEC[i][9:2]);
      chk("R2/R3/R6 vld",   {15'd0, dat_vld},  {15'd0, VEC[i][1]});
      if (VEC[i][1]) chk("R6 byte", {8'd0, dat_byte}, {8'd0, VEC[i][9:2]});
      chk("R2/R3 pause", {15'd0, tx_pause}, {15'd0, VEC[i][0]});
      gap();
    end

    // R4 pairs
    pair_mode = 1'b1;
    send(8'h13); chk("R4 held", {15'd0, dat_vld}, 16'd0); gap();
    send(8'h93); chk("R4 stop vld", {15'd0, dat_vld}, 16'd0);
    chk("R4 stop pause", {15'd0, tx_pause}, 16'd1); gap();
    send(8'h11); chk("R4 held go", {15'd0, dat_vld}, 16'd0); gap();
    send(8'h91); chk("R4 go pause", {15'd0, tx_pause}, 16'd0);
    chk("R4 go vld", {15'd0, dat_vld}, 16'd0); gap();
    send(8'h93); chk("R4 lone second", {7'd0, dat_vld, dat_byte}, 16'h0193); gap();

    // R5 split pair
    send(8'h13);
    send(8'h55);
    chk("R5 first",  {7'd0, dat_vld, dat_byte}, 16'h0113);
    @(negedge clk);
    chk("R5 second", {7'd0, dat_vld, dat_byte}, 16'h0155);
    chk("R5 pause",  {15'd0, tx_pause}, 16'd0);
    gap();
    pair_mode = 1'b0;

    // R10 precedence
    go_c0 = 8'h13;
    send(8'h13); chk("R10 pause", {15'd0, tx_pause}, 16'd1); gap();
    go_c0 = 8'h11;

    // R7 disable
    sw_fc_en = 1'b0;
    @(negedge clk); chk("R7 pause", {15'd0, tx_pause}, 16'd0);
    send(8'h13); chk("R6 disabled pass", {7'd0, dat_vld, dat_byte}, 16'h0113); gap();
    sw_fc_en = 1'b1;

    // R8/R9 single character
    fifo_lvl = 8'd99; @(negedge clk); @(negedge clk);
    chk("R8 below hi", {15'd0, ins_req}, 16'd0);
    fifo_lvl = 8'd100; @(negedge clk);
    chk("R8 stop req", {7'd0, ins_req, ins_byte}, 16'h0113);
    @(negedge clk); @(negedge clk);
    chk("R8 hold", {7'd0, ins_req, ins_byte}, 16'h0113);
    ack_one();
    chk("R8 one per ack", {15'd0, ins_req}, 16'd0);
    repeat (3) @(negedge clk);
    chk("R9 no repeat", {15'd0, ins_req}, 16'd0);
    fifo_lvl = 8'd21; repeat (2) @(negedge clk);
    chk("R9 above lo", {15'd0, ins_req}, 16'd0);
    fifo_lvl = 8'd20; @(negedge clk);
    chk("R9 go req", {7'd0, ins_req, ins_byte}, 16'h0111);
    ack_one();
    chk("R9 go done", {15'd0, ins_req}, 16'd0);

    // R8/R9 pair mode
    pair_mode = 1'b1;
    fifo_lvl = 8'd120; @(negedge clk);
    chk("R8 pair first", {7'd0, ins_req, ins_byte}, 16'h0113);
    ack_one();
    chk("R8 pair second", {7'd0, ins_req, ins_byte}, 16'h0193);
    ack_one();
    chk("R8 pair done", {15'd0, ins_req}, 16'd0);
    fifo_lvl = 8'd5; @(negedge clk);
    chk("R9 pair go", {7'd0, ins_req, ins_byte}, 16'h0111);
    ack_one();
    chk("R9 pair go2", {7'd0, ins_req, ins_byte}, 16'h0191);
    ack_one();

    // R7 withdraws a pending request
    fifo_lvl = 8'd200; @(negedge clk);
    chk("R7 pre", {15'd0, ins_req}, 16'd1);
    sw_fc_en = 1'b0; @(negedge clk);
    chk("R7 withdraw", {15'd0, ins_req}, 16'd0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule